// File: doc/BRIEF.md
# Predicated Tree Reduction Scheduler

This block works out the order in which a downstream execution stage combines the elements of a predicated vector into one value. It performs no arithmetic of its own. After a start pulse it reads the vector length, a predicate mask and a mode select. It then issues a stream of (destination element, source element) index pairs over a valid/ready handshake. The execution stage is expected to compute `elem[dst] = elem[dst] op elem[src]` for each pair it accepts.

There are two modes.

- **Tree mode** reduces the vector in levels. The pairing distance starts at one element and doubles at each level. When only the upper element of a pair is enabled, no pair is issued. Instead, an internal per-slot index table redirects the lower slot to the upper element. Elements never move and the caller's mask is never written.
- **Sequential mode** folds the enabled elements one at a time, in strict element order, into a single accumulator element. A reverse input makes the walk run from the top element down.

In both modes the sequence depends only on the length and the mask. This makes it repeatable, which matters when the operation is order-sensitive, as floating-point operations are.

At the end of a run the block raises a one-cycle done pulse with two results. The first is the element that holds the reduced value. The second is a flag that says no element was enabled.

Top module: `rtsch_tree_sched`

## Requirements
- R1: After reset, `op_valid` and `done` are low, and they stay low until a start pulse arrives.
- R2: With `seq_mode`=0 the pairs come in levels with pairing distance h = 1, 2, 4, … while h < VL. Within a level the lower slots i = 0, 2h, 4h, … are taken in ascending order, paired with slot i+h. With every element enabled, each pair is (dst=i, src=i+h).
- R3: In tree mode, when both slots of a pair are enabled, the block issues (dst = table[i], src = table[i+h]). When only the upper slot is enabled, it issues nothing; table[i] takes table[i+h] and slot i becomes enabled. When the upper slot is disabled, nothing happens.
- R4: Mask bits at positions ≥ VL have no effect, and a slot at or above VL counts as disabled.
- R5: With at least one element enabled, `result_idx` at the done pulse is the element holding the reduced value. In tree mode that is the lowest enabled element. Combining the issued pairs in order yields the reduction of all enabled elements.
- R6: With `seq_mode`=1 and `reverse`=0, the accumulator is the lowest enabled element. Every other enabled element is then issued as (dst=accumulator, src=element) in ascending order, and `result_idx` is the accumulator.
- R7: With `seq_mode`=1 and `reverse`=1, the walk runs from VL-1 down to 0, and the accumulator is the highest enabled element. In tree mode `reverse` has no effect on the pair stream.
- R8: While `op_valid` is high and `op_ready` is low, `op_valid`, `op_dst` and `op_src` hold their values. A pair is consumed on a clock edge where both are high.
- R9: When VL is 0 or 1, no pair is issued, and `done` pulses high for one cycle on the second clock edge after the edge that samples `start`.
- R10: When no mask bit below VL is set, no pair is issued, `done` pulses on the second edge after start, and `no_result` is 1. Otherwise `no_result` is 0.
- R11: A start pulse that arrives while a run is in progress is ignored, and the run in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled only while idle |
| vl | input | $clog2(MAX_VL+1) | Vector length for the run |
| pred_mask | input | MAX_VL | Element enable mask, read only at start |
| seq_mode | input | 1 | 0 = tree schedule, 1 = sequential accumulate |
| reverse | input | 1 | Sequential walk from the top element down |
| op_ready | input | 1 | Execution stage accepts the pair |
| op_valid | output | 1 | A pair is presented |
| op_dst | output | $clog2(MAX_VL) | Destination (and first operand) element |
| op_src | output | $clog2(MAX_VL) | Second operand element |
| done | output | 1 | One-cycle end-of-run pulse |
| no_result | output | 1 | With done: no element was enabled |
| result_idx | output | $clog2(MAX_VL) | With done: element holding the result |

## Verification
Two of this block's functions can land in the same cycle: holding a pair under backpressure (R8), and sampling a new start pulse (R11). The bench provokes the overlap by stalling the ready line on a repeating pattern during a long tree run and pulsing start with VL=0 partway through. It judges the outcome by checking that the presented pair never changes while stalled. It also checks that the accepted pair stream, the result element and the no-result flag all match the schedule computed for the original length and mask.

// File: rtl/rtsch_pkg.sv
package rtsch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2
  } rtsch_state_e;

endpackage

// File: rtl/rtsch_walker.sv
// Cursor over the fixed schedule: tree levels and pairs, or a sequential position.
module rtsch_walker #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 6,
  parameter int VL_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic [VL_W-1:0]  init_vl,
  input  logic             init_seq,
  input  logic             init_rev,
  input  logic             advance,
  output logic [IDX_W-1:0] lo_slot,
  output logic [IDX_W-1:0] hi_slot,
  output logic             hi_ok,
  output logic             finished
);
  localparam int CW = VL_W + 1;

  logic [IDX_W-1:0] base_q;
  logic [VL_W-1:0]  half_q;
  logic [VL_W-1:0]  vl_q;
  logic             seq_q;
  logic             rev_q;
  logic             fin_q;

  logic [CW-1:0] hi_full;
  logic [CW-1:0] next_base;
  logic [CW-1:0] next_hi;
  logic [CW-1:0] dbl_half;

  assign hi_full   = CW'(base_q) + CW'(half_q);
  assign dbl_half  = CW'(half_q) << 1;
  assign next_base = CW'(base_q) + dbl_half;
  assign next_hi   = next_base + CW'(half_q);

  assign lo_slot  = base_q;
  assign hi_slot  = seq_q ? base_q : hi_full[IDX_W-1:0];
  assign hi_ok    = seq_q ? 1'b1 : (hi_full < CW'(vl_q));
  assign finished = fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      half_q <= VL_W'(1);
      vl_q   <= '0;
      seq_q  <= 1'b0;
      rev_q  <= 1'b0;
      fin_q  <= 1'b1;
    end else if (init) begin
      vl_q   <= init_vl;
      seq_q  <= init_seq;
      rev_q  <= init_rev;
      half_q <= VL_W'(1);
      fin_q  <= (init_vl <= VL_W'(1));
      if (init_seq && init_rev && (init_vl != '0))
        base_q <= IDX_W'(init_vl - VL_W'(1));
      else
        base_q <= '0;
    end else if (advance && !fin_q) begin
      if (seq_q) begin
        if (rev_q) begin
          if (base_q == '0) fin_q <= 1'b1;
          else              base_q <= base_q - IDX_W'(1);
        end else begin
          if (CW'(base_q) + CW'(1) >= CW'(vl_q)) fin_q <= 1'b1;
          else                                    base_q <= base_q + IDX_W'(1);
        end
      end else begin
        if (next_hi < CW'(vl_q)) begin
          base_q <= next_base[IDX_W-1:0];
        end else if (dbl_half >= CW'(vl_q)) begin
          fin_q <= 1'b1;
        end else begin
          half_q <= dbl_half[VL_W-1:0];
          base_q <= '0;
        end
      end
    end
  end

  AST_WALK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !fin_q |-> (CW'(base_q) < CW'(vl_q)));  // R4

  AST_HALF_BELOW_VL: assert property (@(posedge clk) disable iff (rst)
    (!fin_q && !seq_q) |-> (half_q < vl_q));  // R2

endmodule

// File: rtl/rtsch_slot_table.sv
// Per-slot element index table plus the private copy of the enable mask.
module rtsch_slot_table #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 6,
  parameter int VL_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic [VL_W-1:0]   init_vl,
  input  logic [MAX_VL-1:0] init_mask,
  input  logic [IDX_W-1:0]  rd_lo,
  input  logic [IDX_W-1:0]  rd_hi,
  input  logic              redirect,
  output logic [IDX_W-1:0]  lo_ix,
  output logic [IDX_W-1:0]  hi_ix,
  output logic              lo_act,
  output logic              hi_act,
  output logic [IDX_W-1:0]  head_ix,
  output logic              any_act
);
  logic [IDX_W-1:0]  ix_q [MAX_VL];
  logic [MAX_VL-1:0] act_q;

  assign lo_ix   = ix_q[rd_lo];
  assign hi_ix   = ix_q[rd_hi];
  assign lo_act  = act_q[rd_lo];
  assign hi_act  = act_q[rd_hi];
  assign head_ix = ix_q[0];
  assign any_act = |act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < MAX_VL; k++) begin
        ix_q[k]  <= IDX_W'(k);
        act_q[k] <= 1'b0;
      end
    end else if (init) begin
      for (int k = 0; k < MAX_VL; k++) begin
        ix_q[k]  <= IDX_W'(k);
        act_q[k] <= init_mask[k] && (init_vl > VL_W'(k));
      end
    end else if (redirect) begin
      ix_q[rd_lo]  <= ix_q[rd_hi];
      act_q[rd_lo] <= 1'b1;
    end
  end

  AST_REDIRECT_UPPER_ONLY: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (hi_act && !lo_act));  // R3

  AST_REDIRECT_SETS_LOWER: assert property (@(posedge clk) disable iff (rst)
    (redirect && !init) |=> act_q[$past(rd_lo)]);  // R3

endmodule

// File: rtl/rtsch_tree_sched.sv
module rtsch_tree_sched #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [MAX_VL-1:0] pred_mask,
  input  logic              seq_mode,
  input  logic              reverse,
  input  logic              op_ready,
  output logic              op_valid,
  output logic [IDX_W-1:0]  op_dst,
  output logic [IDX_W-1:0]  op_src,
  output logic              done,
  output logic              no_result,
  output logic [IDX_W-1:0]  result_idx
);
  import rtsch_pkg::*;

  rtsch_state_e     state_q;
  logic [VL_W-1:0]  vl_q;
  logic             seq_q;
  logic             rev_q;
  logic [IDX_W-1:0] acc_q;
  logic             acc_vld_q;
  logic             op_valid_q;
  logic [IDX_W-1:0] op_dst_q;
  logic [IDX_W-1:0] op_src_q;
  logic             done_q;
  logic             no_res_q;
  logic [IDX_W-1:0] res_q;

  logic             init;
  logic             walk_adv;
  logic [IDX_W-1:0] lo_slot;
  logic [IDX_W-1:0] hi_slot;
  logic             hi_ok;
  logic             walk_fin;
  logic             redirect;
  logic [IDX_W-1:0] lo_ix;
  logic [IDX_W-1:0] hi_ix;
  logic             lo_act;
  logic             hi_act;
  logic [IDX_W-1:0] head_ix;
  logic             any_act;
  logic             scanning;
  logic             issue;
  logic [IDX_W-1:0] issue_dst;
  logic [IDX_W-1:0] issue_src;

  assign init     = (state_q == ST_IDLE) && start;
  assign scanning = (state_q == ST_SCAN) && !walk_fin && any_act;
  assign walk_adv = scanning;

  rtsch_walker #(
    .MAX_VL (MAX_VL),
    .IDX_W  (IDX_W),
    .VL_W   (VL_W)
  ) u_walk (
    .clk      (clk),
    .rst      (rst),
    .init     (init),
    .init_vl  (vl),
    .init_seq (seq_mode),
    .init_rev (reverse),
    .advance  (walk_adv),
    .lo_slot  (lo_slot),
    .hi_slot  (hi_slot),
    .hi_ok    (hi_ok),
    .finished (walk_fin)
  );

  rtsch_slot_table #(
    .MAX_VL (MAX_VL),
    .IDX_W  (IDX_W),
    .VL_W   (VL_W)
  ) u_tab (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .init_vl   (vl),
    .init_mask (pred_mask),
    .rd_lo     (lo_slot),
    .rd_hi     (hi_slot),
    .redirect  (redirect),
    .lo_ix     (lo_ix),
    .hi_ix     (hi_ix),
    .lo_act    (lo_act),
    .hi_act    (hi_act),
    .head_ix   (head_ix),
    .any_act   (any_act)
  );

  // Decide what the current schedule position produces.
  always_comb begin
    issue     = 1'b0;
    issue_dst = lo_ix;
    issue_src = hi_ix;
    redirect  = 1'b0;
    if (scanning) begin
      if (seq_q) begin
        issue     = lo_act && acc_vld_q;
        issue_dst = acc_q;
        issue_src = lo_ix;
      end else begin
        issue    = lo_act && hi_act && hi_ok;
        redirect = !lo_act && hi_act && hi_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      vl_q       <= '0;
      seq_q      <= 1'b0;
      rev_q      <= 1'b0;
      acc_q      <= '0;
      acc_vld_q  <= 1'b0;
      op_valid_q <= 1'b0;
      op_dst_q   <= '0;
      op_src_q   <= '0;
      done_q     <= 1'b0;
      no_res_q   <= 1'b0;
      res_q      <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_SCAN;
            vl_q      <= vl;
            seq_q     <= seq_mode;
            rev_q     <= reverse;
            acc_q     <= '0;
            acc_vld_q <= 1'b0;
          end
        end
        ST_SCAN: begin
          if (walk_fin || !any_act) begin
            done_q   <= 1'b1;
            no_res_q <= !any_act;
            res_q    <= (seq_q && acc_vld_q) ? acc_q : head_ix;
            state_q  <= ST_IDLE;
          end else if (issue) begin
            op_valid_q <= 1'b1;
            op_dst_q   <= issue_dst;
            op_src_q   <= issue_src;
            state_q    <= ST_EMIT;
          end else if (seq_q && lo_act && !acc_vld_q) begin
            acc_q     <= lo_ix;
            acc_vld_q <= 1'b1;
          end
        end
        ST_EMIT: begin
          if (op_ready) begin
            op_valid_q <= 1'b0;
            state_q    <= ST_SCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_valid   = op_valid_q;
  assign op_dst     = op_dst_q;
  assign op_src     = op_src_q;
  assign done       = done_q;
  assign no_result  = no_res_q;
  assign result_idx = res_q;

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_dst) && $stable(op_src)));  // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R9

  AST_DONE_EXCLUDES_OP: assert property (@(posedge clk) disable iff (rst)
    done |-> !op_valid);  // R1

  AST_TREE_UPWARD: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !seq_q) |-> (op_dst < op_src));  // R2

  AST_SEQ_FWD_ORDER: assert property (@(posedge clk) disable iff (rst)
    (op_valid && seq_q && !rev_q) |-> (op_dst < op_src));  // R6

  AST_SEQ_REV_ORDER: assert property (@(posedge clk) disable iff (rst)
    (op_valid && seq_q && rev_q) |-> (op_dst > op_src));  // R7

  AST_SRC_BELOW_VL: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (VL_W'(op_src) < vl_q));  // R4

endmodule

// File: tb/sim_rtsch_tree_sched.sv
`timescale 1ns/1ps
module sim_rtsch_tree_sched;
  localparam int NV = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [6:0]    vl = '0;
  logic [NV-1:0] pred_mask = '0;
  logic          seq_mode = 1'b0;
  logic          reverse = 1'b0;
  logic          op_ready = 1'b0;
  logic          op_valid;
  logic [5:0]    op_dst;
  logic [5:0]    op_src;
  logic          done;
  logic          no_result;
  logic [5:0]    result_idx;

  int n_checks = 0;
  int n_fails  = 0;

  int exp_dst [128];
  int exp_src [128];
  int n_exp;
  int exp_res;
  bit exp_none;
  int got_dst [128];
  int got_src [128];
  int n_got;

  always #2 clk = ~clk;

  rtsch_tree_sched #(.MAX_VL(NV)) u0 (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .vl         (vl),
    .pred_mask  (pred_mask),
    .seq_mode   (seq_mode),
    .reverse    (reverse),
    .op_ready   (op_ready),
    .op_valid   (op_valid),
    .op_dst     (op_dst),
    .op_src     (op_src),
    .done       (done),
    .no_result  (no_result),
    .result_idx (result_idx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_tree(input int v, input logic [NV-1:0] m);
    int ix [64];
    bit ac [64];
    n_exp = 0;
    exp_none = 1'b1;
    for (int k = 0; k < NV; k++) begin
      ix[k] = k;
      ac[k] = (k < v) && m[k];
      if (ac[k]) exp_none = 1'b0;
    end
    for (int h = 1; h < v; h = h * 2) begin
      for (int i = 0; i + h < v; i = i + 2 * h) begin
        if (ac[i] && ac[i+h]) begin
          exp_dst[n_exp] = ix[i];
          exp_src[n_exp] = ix[i+h];
          n_exp++;
        end else if (ac[i+h]) begin
          ix[i] = ix[i+h];
          ac[i] = 1'b1;
        end
      end
    end
    exp_res = ix[0];
  endtask

  task automatic model_seq(input int v, input logic [NV-1:0] m, input bit rv);
    int acc;
    n_exp = 0;
    acc = -1;
    exp_none = 1'b1;
    for (int s = 0; s < v; s++) begin
      int e;
      e = rv ? (v - 1 - s) : s;
      if (m[e]) begin
        exp_none = 1'b0;
        if (acc < 0) acc = e;
        else begin
          exp_dst[n_exp] = acc;
          exp_src[n_exp] = e;
          n_exp++;
        end
      end
    end
    exp_res = (acc < 0) ? 0 : acc;
  endtask

  // Runs one reduction, collects accepted pairs and checks everything against the model.
  task automatic run(input string req, input int v, input logic [NV-1:0] m,
                     input bit sq, input bit rv, input bit stall,
                     input bit inject, input bit fast);
    int  cyc;
    bit  prev_stall;
    int  pd, ps;
    bit  hold_bad;
    bit  seen_done;
    int  done_cyc;
    int  first_bad;
    int  data [64];
    int  sum;
    if (sq) model_seq(v, m, rv);
    else    model_tree(v, m);
    n_got = 0;
    prev_stall = 1'b0;
    pd = 0; ps = 0;
    hold_bad = 1'b0;
    seen_done = 1'b0;
    done_cyc = 0;
    @(negedge clk);
    vl = 7'(v); pred_mask = m; seq_mode = sq; reverse = rv; start = 1'b1;
    op_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (cyc < 3000) begin
      if (done) begin
        seen_done = 1'b1;
        done_cyc = cyc;
        break;
      end
      if (prev_stall && (!op_valid || op_dst != 6'(pd) || op_src != 6'(ps)))
        hold_bad = 1'b1;
      op_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (inject && cyc == 4) begin
        start = 1'b1; vl = '0; pred_mask = '0;
      end else begin
        start = 1'b0; vl = 7'(v); pred_mask = m;
      end
      prev_stall = op_valid && !op_ready;
      pd = int'(op_dst); ps = int'(op_src);
      if (op_valid && op_ready && n_got < 128) begin
        got_dst[n_got] = int'(op_dst);
        got_src[n_got] = int'(op_src);
        n_got++;
      end
      @(negedge clk);
      cyc++;
    end
    op_ready = 1'b0;
    start = 1'b0;
    check(seen_done, req, "done seen", int'(seen_done), 1);
    check(n_got == n_exp, req, "pair count", n_got, n_exp);
    first_bad = -1;
    for (int k = 0; k < n_got && k < n_exp; k++)
      if (first_bad < 0 && (got_dst[k] != exp_dst[k] || got_src[k] != exp_src[k]))
        first_bad = k;
    if (first_bad >= 0)
      check(1'b0, req, "pair dst*64+src", got_dst[first_bad]*64 + got_src[first_bad],
            exp_dst[first_bad]*64 + exp_src[first_bad]);
    else
      check(1'b1, req, "pair stream", 0, 0);
    check(no_result == exp_none, req, "no_result", int'(no_result), int'(exp_none));
    if (!exp_none) begin
      check(int'(result_idx) == exp_res, req, "result_idx", int'(result_idx), exp_res);
      // R5: apply the pairs as an adder would and confirm the full sum lands at result_idx
      sum = 0;
      for (int k = 0; k < NV; k++) begin
        data[k] = 7 * k + 3;
        if (k < v && m[k]) sum += data[k];
      end
      for (int k = 0; k < n_got; k++) data[got_dst[k]] += data[got_src[k]];
      check(data[result_idx] == sum, "R5", "reduced value", data[result_idx], sum);
    end
    if (stall) check(!hold_bad, "R8", "pair held while stalled", int'(hold_bad), 0);
    if (fast) check(done_cyc == 2, req, "done cycle after start", done_cyc, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!op_valid, "R1", "op_valid after reset", int'(op_valid), 0);
    check(!done, "R1", "done after reset", int'(done), 0);

    // R2: all enabled, power-of-two and odd lengths
    run("R2", 8, 64'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R2", 5, 64'h1F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: sparse masks exercising redirect and skip
    run("R3", 8, 64'hB4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R3", 16, 64'h8421, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: bits beyond VL set
    run("R4", 6, 64'hFFFF_0000_0000_0F2A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R4", 7, 64'hFFFF_FFFF_FFFF_FF80 | 64'h41, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5: element 0 disabled, result at first enabled element
    run("R5", 12, 64'hE58, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8: full-length tree with stalls
    run("R8", 64, 64'hDEAD_BEEF_0F0F_5A5A, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R7: reverse has no effect in tree mode
    run("R7", 13, 64'h1B3D, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: sequential forward
    run("R6", 10, 64'h2D6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: sequential reverse
    run("R7", 10, 64'h2D6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R9: trivial lengths
    run("R9", 0, 64'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R9", 1, 64'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R9", 1, 64'h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    // R10: nothing enabled below VL
    run("R10", 16, 64'hFFFF_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R10", 16, 64'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R11: start during a stalled run is ignored
    run("R11", 16, 64'hF3CF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run("R11", 9, 64'h1AB, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule